// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from two serial data lines. Both lines share one bit clock and one left/right frame clock. It turns each line into a left and a right sample word. A frame-clock period has two halves, one for each channel, and each half carries one word. The block handles three framings: right-justified at 16, 18, 20 or 24 bits, an I2S-style framing and a left-justified framing. The last two carry 16- or 24-bit words.

The block runs entirely on the system clock `clk`. It passes the bit clock, the frame clock and the data lines through one shared synchronizer, so all of them see the same delay. It then acts on each rising edge of the synchronized bit clock. A 3-bit format code is strapped at the `fmt_sel_i` pins and taken while reset is held. It cannot be changed until the next reset. Each completed frame is reported as a 24-bit two's-complement word per channel and per line, together with a one-cycle valid pulse.

Top module: `aud_rx_top`

## Requirements
- R1: The format code is taken from `fmt_sel_i` on the last `clk` cycle in which `rst` is high. The codes are: 000 right-justified 16 bit, 001 right-justified 18 bit, 010 right-justified 20 bit, 011 right-justified 24 bit, 100 I2S framing, 101 left-justified.
- R2: Changing `fmt_sel_i` while `rst` is low has no effect on decoding or on `fmt_err_o`.
- R3: Codes 110 and 111 set `fmt_err_o` to 1. In that state `valid_o` never rises and every sample output stays zero. For any legal code `fmt_err_o` is 0.
- R4: Right-justified modes send the word MSB first, with its LSB in the last bit slot before the frame clock toggles. The output is the final N bits of the half, sign-extended to 24 bits. Earlier bits in the half are ignored. Frame clock high marks the left half.
- R5: Right-justified 16-bit decodes correctly with 16, 24 or 32 bit slots per half. The 18-, 20- and 24-bit modes decode correctly with 24 or 32 slots per half.
- R6: In left-justified mode, frame clock high marks the left half. The MSB sits in the first slot after the toggle. Up to 24 bits are placed from output bit 23 downward. Output bits with no slot behind them read zero, and slots beyond 24 are ignored.
- R7: In I2S mode, frame clock low marks the left half. The MSB sits in the second slot after the toggle, and bits are placed as in R6. A word's last bit may fall in the first slot of the next half.
- R8: Both data lines are decoded at once with the same format and framing. Output lane k (bits [24k+23:24k]) belongs to `sdata_i[k]`.
- R9: `valid_o` is a one-cycle pulse raised once a right half completes after its left half. The left and right outputs change only in that cycle, and otherwise hold their values.
- R10: After reset, nothing is reported until a full left half, opened by a frame-clock toggle, and then a right half have been received. The partial half seen before the first toggle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst | input | 1 | Synchronous active-high reset; format code is taken while high |
| fmt_sel_i | input | 3 | Strapped format code |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame (left/right) clock |
| sdata_i | input | LANES | Serial data lines |
| left_o | output | LANES×24 | Left samples, lane k in bits [24k+23:24k] |
| right_o | output | LANES×24 | Right samples, lane k in bits [24k+23:24k] |
| valid_o | output | 1 | One-cycle pulse when a new frame is on the outputs |
| fmt_err_o | output | 1 | Reserved format code selected |

## Verification
A rising bit-clock edge at the pins is seen on the synchronizer output two `clk` cycles later. The frame's outputs and `valid_o` register one cycle after that, so a frame is reported about three cycles after the first bit-clock rise of the following left half. Since that delay is short but depends on where the bit-clock edge falls relative to `clk`, the bench does not sample at fixed cycles. A monitor samples every falling `clk` edge and records outputs only while `valid_o` is high, then compares the recorded frames in order against values the bench computed for the stream it sent. `fmt_err_o` is compared once reset has been released, and the held outputs are compared after the stream has ended and the pipeline has settled.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_BAD = 2'd3
  } frame_mode_e;

  // Decoded strap: framing plus word length used by right-justified modes.
  typedef struct packed {
    frame_mode_e mode;
    logic [4:0]  rj_bits;
  } fmt_cfg_t;

  function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
    fmt_cfg_t c;
    c.mode    = FMT_BAD;
    c.rj_bits = 5'd24;
    case (code)
      3'b000: begin c.mode = FMT_RJ; c.rj_bits = 5'd16; end
      3'b001: begin c.mode = FMT_RJ; c.rj_bits = 5'd18; end
      3'b010: begin c.mode = FMT_RJ; c.rj_bits = 5'd20; end
      3'b011: begin c.mode = FMT_RJ; c.rj_bits = 5'd24; end
      3'b100: c.mode = FMT_I2S;
      3'b101: c.mode = FMT_LJ;
      default: c.mode = FMT_BAD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/aud_rx_ctrl.sv
module aud_rx_ctrl
  import aud_rx_pkg::*;
#(
  parameter  int SAMPLE_W = 24,
  localparam int POS_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  frame_mode_e      mode_i,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  output logic             rise_o,
  output logic             bnd_o,
  output logic             cap_en_o,
  output logic [POS_W-1:0] cap_idx_o,
  output logic             commit_l_o,
  output logic             commit_r_o,
  output logic             frame_done_o
);

  logic             bclk_d;
  logic             lr_d;
  logic             lr_eff_q;
  logic             seen_q;
  logic             have_l_q;
  logic [1:0]       warm_q;
  logic [POS_W-1:0] pos_q;

  logic lr_eff;
  logic left_lvl;
  logic prev_left;
  logic commit;

  always_comb begin
    // I2S framing is left-justified framing with the frame clock late by one slot.
    lr_eff       = (mode_i == FMT_I2S) ? lr_d : lrclk_i;
    left_lvl     = (mode_i != FMT_I2S);
    rise_o       = bclk_i & ~bclk_d;
    bnd_o        = rise_o && (warm_q == 2'd2) && (lr_eff != lr_eff_q);
    commit       = bnd_o && seen_q && (mode_i != FMT_BAD);
    prev_left    = (lr_eff_q == left_lvl);
    commit_l_o   = commit && prev_left;
    commit_r_o   = commit && !prev_left;
    frame_done_o = commit_r_o && have_l_q;
    cap_en_o     = rise_o && !bnd_o && (pos_q < POS_W'(SAMPLE_W));
    cap_idx_o    = POS_W'(SAMPLE_W - 1) - pos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d   <= 1'b0;
      lr_d     <= 1'b0;
      lr_eff_q <= 1'b0;
      seen_q   <= 1'b0;
      have_l_q <= 1'b0;
      warm_q   <= 2'd0;
      pos_q    <= POS_W'(SAMPLE_W);
    end else begin
      bclk_d <= bclk_i;
      if (rise_o) begin
        lr_d     <= lrclk_i;
        lr_eff_q <= lr_eff;
        if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        if (bnd_o) begin
          seen_q <= 1'b1;
          pos_q  <= POS_W'(1);
        end else if (pos_q < POS_W'(SAMPLE_W)) begin
          pos_q <= pos_q + POS_W'(1);
        end
      end
      if (commit_l_o)      have_l_q <= 1'b1;
      else if (commit_r_o) have_l_q <= 1'b0;
    end
  end

endmodule

// File: rtl/aud_rx_lane.sv
module aud_rx_lane
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int LEN_W    = 5,
  parameter int POS_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  frame_mode_e         mode_i,
  input  logic [LEN_W-1:0]    rj_bits_i,
  input  logic                rise_i,
  input  logic                bnd_i,
  input  logic                cap_en_i,
  input  logic [POS_W-1:0]    cap_idx_i,
  input  logic                sdata_i,
  input  logic                commit_l_i,
  input  logic                frame_done_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  logic [SAMPLE_W-1:0] shift_q;
  logic [SAMPLE_W-1:0] word_q;
  logic [SAMPLE_W-1:0] l_pend_q;
  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] right_q;
  logic [SAMPLE_W-1:0] cur;

  // Keep the low n bits and copy bit n-1 upward.
  function automatic logic [SAMPLE_W-1:0] rj_extract(input logic [SAMPLE_W-1:0] v,
                                                     input logic [LEN_W-1:0]    n);
    logic [SAMPLE_W-1:0] r;
    int top;
    top = (n == '0) ? 0 : int'(n) - 1;
    if (top > SAMPLE_W - 1) top = SAMPLE_W - 1;
    for (int i = 0; i < SAMPLE_W; i++) begin
      r[i] = (i <= top) ? v[i] : v[top];
    end
    return r;
  endfunction

  always_comb begin
    cur = (mode_i == FMT_RJ) ? rj_extract(shift_q, rj_bits_i) : word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      word_q   <= '0;
      l_pend_q <= '0;
      left_q   <= '0;
      right_q  <= '0;
    end else begin
      if (rise_i) shift_q <= {shift_q[SAMPLE_W-2:0], sdata_i};
      if (bnd_i) begin
        word_q             <= '0;
        word_q[SAMPLE_W-1] <= sdata_i;
      end else if (cap_en_i) begin
        word_q[cap_idx_i] <= sdata_i;
      end
      if (commit_l_i) l_pend_q <= cur;
      if (frame_done_i) begin
        left_q  <= l_pend_q;
        right_q <= cur;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;

endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
  import aud_rx_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [2:0]                      fmt_sel_i,
  input  logic                            bclk_i,
  input  logic                            lrclk_i,
  input  logic [LANES-1:0]                sdata_i,
  output logic [LANES-1:0][SAMPLE_W-1:0]  left_o,
  output logic [LANES-1:0][SAMPLE_W-1:0]  right_o,
  output logic                            valid_o,
  output logic                            fmt_err_o
);

  localparam int POS_W  = $clog2(SAMPLE_W + 1);
  localparam int LEN_W  = 5;
  localparam int SYNC_W = LANES + 2;

  logic [2:0]  fmt_q;
  logic        err_q;
  logic        valid_q;
  fmt_cfg_t    cfg_in;
  fmt_cfg_t    cfg_q;

  logic [SYNC_W-1:0] sync_out;
  logic              bclk_s;
  logic              lr_s;
  logic [LANES-1:0]  data_s;

  logic             rise, bnd, cap_en, commit_l, commit_r, frame_done;
  logic [POS_W-1:0] cap_idx;

  always_comb begin
    cfg_in = decode_fmt(fmt_sel_i);
    cfg_q  = decode_fmt(fmt_q);
  end

  // Strap is followed only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q <= fmt_sel_i;
      err_q <= (cfg_in.mode == FMT_BAD);
    end
  end

  aud_rx_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sdata_i, lrclk_i, bclk_i}),
    .q_o (sync_out)
  );

  assign bclk_s = sync_out[0];
  assign lr_s   = sync_out[1];
  assign data_s = sync_out[SYNC_W-1:2];

  aud_rx_ctrl #(
    .SAMPLE_W (SAMPLE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (cfg_q.mode),
    .bclk_i       (bclk_s),
    .lrclk_i      (lr_s),
    .rise_o       (rise),
    .bnd_o        (bnd),
    .cap_en_o     (cap_en),
    .cap_idx_o    (cap_idx),
    .commit_l_o   (commit_l),
    .commit_r_o   (commit_r),
    .frame_done_o (frame_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aud_rx_lane #(
      .SAMPLE_W (SAMPLE_W),
      .LEN_W    (LEN_W),
      .POS_W    (POS_W)
    ) u_lane (
      .clk          (clk),
      .rst          (rst),
      .mode_i       (cfg_q.mode),
      .rj_bits_i    (cfg_q.rj_bits),
      .rise_i       (rise),
      .bnd_i        (bnd),
      .cap_en_i     (cap_en),
      .cap_idx_i    (cap_idx),
      .sdata_i      (data_s[g]),
      .commit_l_i   (commit_l),
      .frame_done_i (frame_done),
      .left_o       (left_o[g]),
      .right_o      (right_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= frame_done;
  end

  assign valid_o   = valid_q;
  assign fmt_err_o = err_q;

  logic unused_commit_r;
  assign unused_commit_r = commit_r;

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int LANES    = 2,
  parameter int SAMPLE_W = 24
) (
  input logic                           clk,
  input logic                           rst,
  input logic [LANES-1:0][SAMPLE_W-1:0] left_o,
  input logic [LANES-1:0][SAMPLE_W-1:0] right_o,
  input logic                           valid_o,
  input logic                           fmt_err_o
);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_err_o |-> !valid_o);

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_err_o |-> (left_o == '0 && right_o == '0));

  // R2
  err_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(fmt_err_o));

endmodule

bind aud_rx_top aud_rx_chk #(
  .LANES    (LANES),
  .SAMPLE_W (SAMPLE_W)
) u_aud_rx_chk (
  .clk       (clk),
  .rst       (rst),
  .left_o    (left_o),
  .right_o   (right_o),
  .valid_o   (valid_o),
  .fmt_err_o (fmt_err_o)
);

// File: tb/aud_rx_top_bench.sv
module aud_rx_top_bench;

  localparam int LANES = 2;
  localparam int SW    = 24;
  localparam int MAXF  = 16;
  localparam int MAXS  = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                         rst = 1'b1;
  logic [2:0]                   fmt_sel = 3'b000;
  logic                         bclk = 1'b0;
  logic                         lrclk = 1'b0;
  logic [LANES-1:0]             sdata = '0;
  logic [LANES-1:0][SW-1:0]     left_o;
  logic [LANES-1:0][SW-1:0]     right_o;
  logic                         valid_o;
  logic                         fmt_err_o;

  int checks = 0;
  int errors = 0;
  int nvalid = 0;

  logic [SW-1:0] exp_l [LANES][MAXF];
  logic [SW-1:0] exp_r [LANES][MAXF];
  logic [SW-1:0] got_l [LANES][MAXF];
  logic [SW-1:0] got_r [LANES][MAXF];
  logic          lr_log  [MAXS];
  logic          lr_phys [MAXS];
  logic          dat     [LANES][MAXS];

  aud_rx_top u_aud_rx_top (
    .clk       (clk),
    .rst       (rst),
    .fmt_sel_i (fmt_sel),
    .bclk_i    (bclk),
    .lrclk_i   (lrclk),
    .sdata_i   (sdata),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .fmt_err_o (fmt_err_o)
  );

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (nvalid < MAXF) begin
        for (int ln = 0; ln < LANES; ln++) begin
          got_l[ln][nvalid] = left_o[ln];
          got_r[ln][nvalid] = right_o[ln];
        end
      end
      nvalid++;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic int rj_len(input logic [2:0] code);
    case (code)
      3'b000:  return 16;
      3'b001:  return 18;
      3'b010:  return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [SW-1:0] sext(input logic [SW-1:0] v, input int n);
    logic [31:0] m;
    logic [31:0] r;
    m = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    r = {8'd0, v} & m;
    if (v[n-1]) r = r | ~m;
    return r[SW-1:0];
  endfunction

  task automatic do_reset(input logic [2:0] code, input logic idle_lr);
    rst     = 1'b1;
    fmt_sel = code;
    bclk    = 1'b0;
    lrclk   = idle_lr;
    sdata   = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] code, input logic [2:0] late_code, input int half,
                     input int src_w, input int nfr, input string tag);
    bit   rj, i2s, bad;
    int   n, t, nsl, exp_n;
    logic left_lvl;
    logic [SW-1:0] raw_l [LANES];
    logic [SW-1:0] raw_r [LANES];
    logic [SW-1:0] val;
    logic [31:0]   mask;

    bad      = (code >= 3'd6);
    rj       = (code < 3'd4);
    i2s      = (code == 3'd4);
    n        = rj ? rj_len(code) : src_w;
    left_lvl = !i2s;
    mask     = (32'd1 << n) - 32'd1;
    t = 0;
    for (int k = 0; k < 4; k++) begin
      lr_log[t] = !left_lvl;
      for (int ln = 0; ln < LANES; ln++) dat[ln][t] = 1'($urandom);
      t++;
    end
    for (int f = 0; f < nfr; f++) begin
      for (int ln = 0; ln < LANES; ln++) begin
        if (f == 0 && ln == 0) begin
          raw_l[ln] = SW'(32'd1 << (n - 1));
          raw_r[ln] = SW'((32'd1 << (n - 1)) - 32'd1);
        end else begin
          raw_l[ln] = SW'($urandom & mask);
          raw_r[ln] = SW'($urandom & mask);
        end
        exp_l[ln][f] = rj ? sext(raw_l[ln], n) : SW'(raw_l[ln] << (SW - n));
        exp_r[ln][f] = rj ? sext(raw_r[ln], n) : SW'(raw_r[ln] << (SW - n));
      end
      for (int ch = 0; ch < 2; ch++) begin
        for (int k = 0; k < half; k++) begin
          lr_log[t] = (ch == 0) ? left_lvl : !left_lvl;
          for (int ln = 0; ln < LANES; ln++) begin
            val = (ch == 0) ? raw_l[ln] : raw_r[ln];
            if (rj) dat[ln][t] = (k < half - n) ? 1'($urandom) : val[half-1-k];
            else    dat[ln][t] = (k < n) ? val[n-1-k] : 1'b0;
          end
          t++;
        end
      end
    end
    for (int k = 0; k < half; k++) begin
      lr_log[t] = left_lvl;
      for (int ln = 0; ln < LANES; ln++) dat[ln][t] = 1'b0;
      t++;
    end
    nsl = t;
    for (int i = 0; i < nsl; i++) begin
      if (i2s) lr_phys[i] = (i + 1 < nsl) ? lr_log[i+1] : left_lvl;
      else     lr_phys[i] = lr_log[i];
    end

    do_reset(code, lr_phys[0]);
    check({tag, " R1 R3 fmt_err after reset"}, 32'(fmt_err_o), 32'(bad));
    check({tag, " R9 valid low after reset"}, 32'(valid_o), 32'd0);
    check({tag, " R9 left zero after reset"}, 32'(left_o[0]), 32'd0);
    if (late_code != code) fmt_sel = late_code;
    nvalid = 0;

    for (int i = 0; i < nsl; i++) begin
      @(negedge clk);
      bclk  = 1'b0;
      lrclk = lr_phys[i];
      for (int ln = 0; ln < LANES; ln++) sdata[ln] = dat[ln][i];
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    bclk = 1'b0;
    repeat (10) @(negedge clk);

    exp_n = bad ? 0 : nfr;
    check({tag, " R9 R10 frame count"}, 32'(nvalid), 32'(exp_n));
    check({tag, " R2 R3 fmt_err held"}, 32'(fmt_err_o), 32'(bad));
    for (int f = 0; f < nfr && f < nvalid && f < MAXF; f++) begin
      for (int ln = 0; ln < LANES; ln++) begin
        check($sformatf("%s R8 lane %0d frame %0d left", tag, ln, f), 32'(got_l[ln][f]), 32'(exp_l[ln][f]));
        check($sformatf("%s R8 lane %0d frame %0d right", tag, ln, f), 32'(got_r[ln][f]), 32'(exp_r[ln][f]));
      end
    end
    if (bad) begin
      check({tag, " R3 left zero"}, 32'(left_o[0] | left_o[1]), 32'd0);
      check({tag, " R3 right zero"}, 32'(right_o[0] | right_o[1]), 32'd0);
    end else begin
      check({tag, " R9 left held"}, 32'(left_o[1]), 32'(exp_l[1][nfr-1]));
      check({tag, " R9 right held"}, 32'(right_o[0]), 32'(exp_r[0][nfr-1]));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run(3'b000, 3'b000, 16, 16, 5, "R1 R4 R5 rj16 32fs");
    run(3'b000, 3'b000, 24, 16, 5, "R4 R5 rj16 48fs");
    run(3'b000, 3'b000, 32, 16, 5, "R4 R5 rj16 64fs");
    run(3'b001, 3'b001, 24, 18, 5, "R1 R4 R5 rj18 48fs");
    run(3'b010, 3'b010, 32, 20, 5, "R1 R4 R5 rj20 64fs");
    run(3'b011, 3'b011, 24, 24, 5, "R4 R5 rj24 48fs");
    run(3'b011, 3'b011, 32, 24, 5, "R1 R4 R5 rj24 64fs");
    run(3'b101, 3'b101, 16, 16, 5, "R1 R6 lj16 32fs");
    run(3'b101, 3'b101, 32, 24, 5, "R6 lj24 64fs");
    run(3'b100, 3'b100, 24, 24, 5, "R1 R7 i2s24 48fs");
    run(3'b100, 3'b100, 32, 16, 5, "R7 i2s16 64fs");
    run(3'b011, 3'b101, 32, 24, 4, "R2 late strap change");
    run(3'b100, 3'b111, 24, 24, 4, "R2 late reserved code");
    run(3'b110, 3'b110, 32, 24, 3, "R3 code 110");
    run(3'b111, 3'b000, 32, 24, 3, "R3 code 111");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule